// File: doc/BRIEF.md
# Descriptor Fetch Sequencer

This block serves descriptor requests from the transmit and receive engines. Each accepted request claims a slot. The slot records the requester's tag, and its number selects a fixed region of a small local descriptor RAM. The slot then moves through a fixed sequence. First it asks the queue manager for a dequeue. When the answer comes back, it reports the fetch status to the requester. If the queue was not empty, it asks the DMA engine to copy the descriptor from the returned host address into its RAM region. When the DMA engine reports the copy done, it sends the dequeue commit. Last, it streams the descriptor out of the RAM on an AXI-Stream output whose TID carries the requester's tag.

Several fetches may be in flight at once, one per slot. Dequeue responses and DMA completions name the slot they belong to, so they may return in any order. Fetch status is always reported before any data moves. The commit is held back until the descriptor is known to be in local RAM.

Every stream channel is valid/ready. An output raises valid and keeps both valid and its payload unchanged until ready is seen at a clock edge. When slots of equal standing compete for one output, the lowest slot number wins, but only at the moment the channel is idle or has just completed a transfer. The dequeue response and DMA completion inputs are always accepted: their ready outputs are tied high. The RAM write port belongs to the DMA engine model and has no handshake.

Top module: `descriptor_fetch_seq`

## Requirements
- R1: After reset, req_ready is 1 and dq_req_valid, st_valid, rd_valid, cm_valid and m_tvalid are all 0.
- R2: An accepted request (req_valid and req_ready at an edge) produces a dequeue request carrying the request's queue number and the slot that holds the fetch.
- R3: A dequeue response for a slot produces one status transfer carrying that slot's requester tag and the response's empty flag, before any DMA read request for that slot.
- R4: For a non-empty response, after the status transfer a DMA read request is issued carrying the returned host address and the slot number. The RAM region to fill is words slot*DESC_WORDS up to slot*DESC_WORDS+DESC_WORDS-1.
- R5: The dequeue commit for a fetch carries the operation handle from its dequeue response and is offered only after the DMA completion for that slot has been received.
- R6: After the commit, the slot's descriptor is streamed as DESC_WORDS beats. Beat b carries RAM word slot*DESC_WORDS+b, TLAST is set only on the final beat, and TID equals the requester tag.
- R7: On every output stream, while valid is 1 and ready is 0, valid stays 1 and the payload stays unchanged at the next edge.
- R8: At most SLOTS fetches are held at once, and req_ready is 0 while all slots are busy. A slot frees once its TLAST beat transfers, or once an empty status transfers, and req_ready then returns to 1.
- R9: For an empty response, the slot frees after the status transfer, and no DMA read, commit or stream is issued for it.
- R10: Dequeue responses may arrive in any slot order, and each status carries the tag of the slot named by its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Descriptor request valid |
| req_ready | output | 1 | A slot is free to take a request |
| req_tag | input | TAG_W | Requester tag, returned on status and TID |
| req_queue | input | QUEUE_W | Queue to fetch from |
| dq_req_valid | output | 1 | Dequeue request valid |
| dq_req_ready | input | 1 | Queue manager accepts dequeue request |
| dq_req_queue | output | QUEUE_W | Queue to dequeue |
| dq_req_slot | output | SLOT_W | Slot number, echoed in the response |
| dq_resp_valid | input | 1 | Dequeue response valid |
| dq_resp_ready | output | 1 | Always 1 |
| dq_resp_slot | input | SLOT_W | Slot the response belongs to |
| dq_resp_empty | input | 1 | Queue was empty |
| dq_resp_addr | input | ADDR_W | Host address of the descriptor |
| dq_resp_op | input | OP_W | Operation handle for the commit |
| st_valid | output | 1 | Fetch status valid |
| st_ready | input | 1 | Requester accepts status |
| st_tag | output | TAG_W | Requester tag |
| st_empty | output | 1 | Queue was empty, nothing will follow |
| rd_valid | output | 1 | DMA read request valid |
| rd_ready | input | 1 | DMA engine accepts request |
| rd_addr | output | ADDR_W | Host address to read |
| rd_slot | output | SLOT_W | Target RAM slot |
| rd_done_valid | input | 1 | DMA read completion valid |
| rd_done_ready | output | 1 | Always 1 |
| rd_done_slot | input | SLOT_W | Slot whose copy finished |
| ram_we | input | 1 | Local RAM write enable |
| ram_waddr | input | RAM_AW | Local RAM word address |
| ram_wdata | input | DATA_W | Local RAM write data |
| cm_valid | output | 1 | Dequeue commit valid |
| cm_ready | input | 1 | Queue manager accepts commit |
| cm_op | output | OP_W | Operation handle to commit |
| m_tvalid | output | 1 | Descriptor stream valid |
| m_tready | input | 1 | Descriptor stream ready |
| m_tdata | output | DATA_W | Descriptor word |
| m_tlast | output | 1 | Final word of a descriptor |
| m_tid | output | TAG_W | Requester tag |

## Verification
The assertions take for granted that the inputs behave as a well-formed queue manager and DMA engine would:
- A dequeue response names only a slot whose request has gone out and has not yet been answered.
- A DMA completion names only a slot whose read request has been taken.
- RAM writes land only in the region of a slot that is waiting for its copy to finish.
- Each completion follows the writes it covers.

The bench keeps within these rules by taking every slot number from the block's own dequeue and read requests before it answers. It writes a slot's RAM region only between taking that slot's read request and pulsing its completion.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic [3:0] {
    S_FREE,
    S_DQ_REQ,
    S_DQ_WAIT,
    S_STATUS,
    S_RD_REQ,
    S_RD_WAIT,
    S_COMMIT,
    S_OUTQ,
    S_STREAM
  } slot_state_e;
endpackage

// File: rtl/dfs_pick.sv
// Lowest-index selector that freezes its choice while the selected
// entry is presented on a stream and not yet accepted.
module dfs_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cand,
  input  logic         fire,
  output logic         any,
  output logic [W-1:0] sel
);
  logic         hold_q;
  logic [W-1:0] held_q;
  logic [W-1:0] low;

  always_comb begin
    low = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) low = W'(i);
    end
  end

  assign any = |cand;
  assign sel = hold_q ? held_q : low;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      held_q <= '0;
    end else begin
      hold_q <= any && !fire;
      held_q <= sel;
    end
  end
endmodule

// File: rtl/dfs_desc_ram.sv
// Local descriptor store: one write port for the DMA engine,
// one asynchronous read port for the stream reader.
module dfs_desc_ram #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/descriptor_fetch_seq.sv
module descriptor_fetch_seq
  import dfs_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int TAG_W      = 4,
  parameter int QUEUE_W    = 8,
  parameter int ADDR_W     = 32,
  parameter int OP_W       = 4,
  parameter int DATA_W     = 32,
  parameter int DESC_WORDS = 2,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int RAM_DEPTH = SLOTS * DESC_WORDS,
  localparam int RAM_AW    = $clog2(RAM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic [QUEUE_W-1:0] req_queue,
  output logic               dq_req_valid,
  input  logic               dq_req_ready,
  output logic [QUEUE_W-1:0] dq_req_queue,
  output logic [SLOT_W-1:0]  dq_req_slot,
  input  logic               dq_resp_valid,
  output logic               dq_resp_ready,
  input  logic [SLOT_W-1:0]  dq_resp_slot,
  input  logic               dq_resp_empty,
  input  logic [ADDR_W-1:0]  dq_resp_addr,
  input  logic [OP_W-1:0]    dq_resp_op,
  output logic               st_valid,
  input  logic               st_ready,
  output logic [TAG_W-1:0]   st_tag,
  output logic               st_empty,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic [SLOT_W-1:0]  rd_slot,
  input  logic               rd_done_valid,
  output logic               rd_done_ready,
  input  logic [SLOT_W-1:0]  rd_done_slot,
  input  logic               ram_we,
  input  logic [RAM_AW-1:0]  ram_waddr,
  input  logic [DATA_W-1:0]  ram_wdata,
  output logic               cm_valid,
  input  logic               cm_ready,
  output logic [OP_W-1:0]    cm_op,
  output logic               m_tvalid,
  input  logic               m_tready,
  output logic [DATA_W-1:0]  m_tdata,
  output logic               m_tlast,
  output logic [TAG_W-1:0]   m_tid
);
  localparam int BEAT_W = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1;

  slot_state_e        state_q [SLOTS];
  logic [TAG_W-1:0]   tag_q   [SLOTS];
  logic [QUEUE_W-1:0] queue_q [SLOTS];
  logic [ADDR_W-1:0]  addr_q  [SLOTS];
  logic [OP_W-1:0]    op_q    [SLOTS];
  logic [SLOTS-1:0]   empty_q;

  logic [SLOTS-1:0] free_v, dqr_v, st_v, rdr_v, cm_v, oq_v;
  logic [SLOT_W-1:0] free_sel, dq_sel, st_sel, rd_sel, cm_sel, oq_sel;
  logic dq_any, st_any, rd_any, cm_any, oq_any;

  // stream reader
  logic              act_q;
  logic [SLOT_W-1:0] cur_q;
  logic [BEAT_W-1:0] beat_q;
  logic [RAM_AW-1:0] raddr;
  logic              start;

  logic req_fire, dq_fire, st_fire, rd_fire, cm_fire, end_fire;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      free_v[i] = (state_q[i] == S_FREE);
      dqr_v[i]  = (state_q[i] == S_DQ_REQ);
      st_v[i]   = (state_q[i] == S_STATUS);
      rdr_v[i]  = (state_q[i] == S_RD_REQ);
      cm_v[i]   = (state_q[i] == S_COMMIT);
      oq_v[i]   = (state_q[i] == S_OUTQ);
    end
    free_sel = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (free_v[i]) free_sel = SLOT_W'(i);
    end
  end

  dfs_pick #(.N(SLOTS), .W(SLOT_W)) u_pick_dq (
    .clk(clk), .rst(rst), .cand(dqr_v), .fire(dq_fire), .any(dq_any), .sel(dq_sel));
  dfs_pick #(.N(SLOTS), .W(SLOT_W)) u_pick_st (
    .clk(clk), .rst(rst), .cand(st_v), .fire(st_fire), .any(st_any), .sel(st_sel));
  dfs_pick #(.N(SLOTS), .W(SLOT_W)) u_pick_rd (
    .clk(clk), .rst(rst), .cand(rdr_v), .fire(rd_fire), .any(rd_any), .sel(rd_sel));
  dfs_pick #(.N(SLOTS), .W(SLOT_W)) u_pick_cm (
    .clk(clk), .rst(rst), .cand(cm_v), .fire(cm_fire), .any(cm_any), .sel(cm_sel));
  dfs_pick #(.N(SLOTS), .W(SLOT_W)) u_pick_oq (
    .clk(clk), .rst(rst), .cand(oq_v), .fire(start), .any(oq_any), .sel(oq_sel));

  assign req_ready     = |free_v;
  assign dq_resp_ready = 1'b1;
  assign rd_done_ready = 1'b1;

  assign dq_req_valid = dq_any;
  assign dq_req_slot  = dq_sel;
  assign dq_req_queue = queue_q[dq_sel];

  assign st_valid = st_any;
  assign st_tag   = tag_q[st_sel];
  assign st_empty = empty_q[st_sel];

  assign rd_valid = rd_any;
  assign rd_addr  = addr_q[rd_sel];
  assign rd_slot  = rd_sel;

  assign cm_valid = cm_any;
  assign cm_op    = op_q[cm_sel];

  assign req_fire = req_valid && req_ready;
  assign dq_fire  = dq_req_valid && dq_req_ready;
  assign st_fire  = st_valid && st_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign cm_fire  = cm_valid && cm_ready;
  assign start    = !act_q && oq_any;

  assign raddr    = RAM_AW'(cur_q) * RAM_AW'(DESC_WORDS) + RAM_AW'(beat_q);
  assign m_tvalid = act_q;
  assign m_tlast  = (beat_q == BEAT_W'(DESC_WORDS - 1));
  assign m_tid    = tag_q[cur_q];
  assign end_fire = act_q && m_tready && m_tlast;

  dfs_desc_ram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(raddr), .rdata(m_tdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cur_q  <= '0;
      beat_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      cur_q  <= oq_sel;
      beat_q <= '0;
    end else if (act_q && m_tready) begin
      if (m_tlast) act_q <= 1'b0;
      else         beat_q <= beat_q + 1'b1;
    end
  end

  // per-slot sequence; each step is driven by the event addressed to it
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) begin
        state_q[i] <= S_FREE;
        tag_q[i]   <= '0;
        queue_q[i] <= '0;
        addr_q[i]  <= '0;
        op_q[i]    <= '0;
        empty_q[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        case (state_q[i])
          S_FREE: if (req_fire && free_sel == SLOT_W'(i)) begin
            state_q[i] <= S_DQ_REQ;
            tag_q[i]   <= req_tag;
            queue_q[i] <= req_queue;
          end
          S_DQ_REQ: if (dq_fire && dq_sel == SLOT_W'(i)) state_q[i] <= S_DQ_WAIT;
          S_DQ_WAIT: if (dq_resp_valid && dq_resp_slot == SLOT_W'(i)) begin
            state_q[i] <= S_STATUS;
            empty_q[i] <= dq_resp_empty;
            addr_q[i]  <= dq_resp_addr;
            op_q[i]    <= dq_resp_op;
          end
          S_STATUS: if (st_fire && st_sel == SLOT_W'(i))
            state_q[i] <= empty_q[i] ? S_FREE : S_RD_REQ;
          S_RD_REQ: if (rd_fire && rd_sel == SLOT_W'(i)) state_q[i] <= S_RD_WAIT;
          S_RD_WAIT: if (rd_done_valid && rd_done_slot == SLOT_W'(i)) state_q[i] <= S_COMMIT;
          S_COMMIT: if (cm_fire && cm_sel == SLOT_W'(i)) state_q[i] <= S_OUTQ;
          S_OUTQ: if (start && oq_sel == SLOT_W'(i)) state_q[i] <= S_STREAM;
          S_STREAM: if (end_fire && cur_q == SLOT_W'(i)) state_q[i] <= S_FREE;
          default: state_q[i] <= S_FREE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
  parameter int SLOTS   = 4,
  parameter int TAG_W   = 4,
  parameter int QUEUE_W = 8,
  parameter int ADDR_W  = 32,
  parameter int OP_W    = 4,
  parameter int DATA_W  = 32,
  parameter int SLOT_W  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               dq_req_valid,
  input logic               dq_req_ready,
  input logic [QUEUE_W-1:0] dq_req_queue,
  input logic [SLOT_W-1:0]  dq_req_slot,
  input logic               st_valid,
  input logic               st_ready,
  input logic [TAG_W-1:0]   st_tag,
  input logic               st_empty,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [SLOT_W-1:0]  rd_slot,
  input logic               rd_done_valid,
  input logic               cm_valid,
  input logic               cm_ready,
  input logic [OP_W-1:0]    cm_op,
  input logic               m_tvalid,
  input logic               m_tready,
  input logic [DATA_W-1:0]  m_tdata,
  input logic               m_tlast,
  input logic [TAG_W-1:0]   m_tid
);
  logic [7:0] rd_pend, cm_pend, live;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= '0;
      cm_pend <= '0;
      live    <= '0;
    end else begin
      rd_pend <= rd_pend + 8'(st_valid && st_ready && !st_empty) - 8'(rd_valid && rd_ready);
      cm_pend <= cm_pend + 8'(rd_done_valid) - 8'(cm_valid && cm_ready);
      live    <= live + 8'(req_valid && req_ready)
                      - 8'(m_tvalid && m_tready && m_tlast)
                      - 8'(st_valid && st_ready && st_empty);
    end
  end

  assert_hold_dq_R7: assert property (@(posedge clk) disable iff (rst)
    dq_req_valid && !dq_req_ready |=> dq_req_valid && $stable(dq_req_queue) && $stable(dq_req_slot));
  assert_hold_st_R7: assert property (@(posedge clk) disable iff (rst)
    st_valid && !st_ready |=> st_valid && $stable(st_tag) && $stable(st_empty));
  assert_hold_rd_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_slot));
  assert_hold_cm_R7: assert property (@(posedge clk) disable iff (rst)
    cm_valid && !cm_ready |=> cm_valid && $stable(cm_op));
  assert_hold_m_R7: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tid));
  assert_read_after_status_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_pend != 8'd0);
  assert_commit_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    cm_valid |-> cm_pend != 8'd0);
  assert_slot_bound_R8: assert property (@(posedge clk) disable iff (rst)
    live <= 8'(SLOTS));
  assert_ready_means_room_R8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> live < 8'(SLOTS));
  assert_burst_runs_R6: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_tready && !m_tlast |=> m_tvalid);
endmodule

bind descriptor_fetch_seq dfs_checker #(
  .SLOTS(SLOTS), .TAG_W(TAG_W), .QUEUE_W(QUEUE_W), .ADDR_W(ADDR_W),
  .OP_W(OP_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)
) u_dfs_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .dq_req_valid(dq_req_valid), .dq_req_ready(dq_req_ready),
  .dq_req_queue(dq_req_queue), .dq_req_slot(dq_req_slot),
  .st_valid(st_valid), .st_ready(st_ready), .st_tag(st_tag), .st_empty(st_empty),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_slot(rd_slot),
  .rd_done_valid(rd_done_valid), .cm_valid(cm_valid), .cm_ready(cm_ready),
  .cm_op(cm_op), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
  .m_tlast(m_tlast), .m_tid(m_tid)
);

// File: tb/tb_descriptor_fetch_seq.sv
`timescale 1ns/1ps
module tb_descriptor_fetch_seq;
  localparam int SLOTS = 4, TAG_W = 4, QUEUE_W = 8, ADDR_W = 32, OP_W = 4;
  localparam int DATA_W = 32, DESC_WORDS = 2, SLOT_W = 2, RAM_AW = 3;
  localparam int LIMIT = 1000;

  logic clk = 1'b0;
  logic rst;
  logic req_valid = 0, req_ready;
  logic [TAG_W-1:0] req_tag = '0;
  logic [QUEUE_W-1:0] req_queue = '0;
  logic dq_req_valid, dq_req_ready = 0;
  logic [QUEUE_W-1:0] dq_req_queue;
  logic [SLOT_W-1:0] dq_req_slot;
  logic dq_resp_valid = 0, dq_resp_ready;
  logic [SLOT_W-1:0] dq_resp_slot = '0;
  logic dq_resp_empty = 0;
  logic [ADDR_W-1:0] dq_resp_addr = '0;
  logic [OP_W-1:0] dq_resp_op = '0;
  logic st_valid, st_ready = 0, st_empty;
  logic [TAG_W-1:0] st_tag;
  logic rd_valid, rd_ready = 0;
  logic [ADDR_W-1:0] rd_addr;
  logic [SLOT_W-1:0] rd_slot;
  logic rd_done_valid = 0, rd_done_ready;
  logic [SLOT_W-1:0] rd_done_slot = '0;
  logic ram_we = 0;
  logic [RAM_AW-1:0] ram_waddr = '0;
  logic [DATA_W-1:0] ram_wdata = '0;
  logic cm_valid, cm_ready = 0;
  logic [OP_W-1:0] cm_op;
  logic m_tvalid, m_tready = 0, m_tlast;
  logic [DATA_W-1:0] m_tdata;
  logic [TAG_W-1:0] m_tid;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  descriptor_fetch_seq #(.SLOTS(SLOTS), .TAG_W(TAG_W), .QUEUE_W(QUEUE_W),
    .ADDR_W(ADDR_W), .OP_W(OP_W), .DATA_W(DATA_W), .DESC_WORDS(DESC_WORDS)) dut (.*);

  function automatic logic [DATA_W-1:0] exp_word(input logic [TAG_W-1:0] t, input int w);
    return 32'hC0DE_0000 | (DATA_W'(t) << 8) | DATA_W'(w);
  endfunction

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_hi(ref logic sig, input string req);
    int n = 0;
    while (!sig && n < LIMIT) begin @(negedge clk); n++; end
    check(sig, req, 0, 1);
  endtask

  task automatic send_req(input logic [TAG_W-1:0] t, input logic [QUEUE_W-1:0] q);
    req_valid = 1; req_tag = t; req_queue = q;
    wait_hi(req_ready, "R8 req_ready");
    @(negedge clk); req_valid = 0;
  endtask

  task automatic take_dq(input logic [QUEUE_W-1:0] q, output logic [SLOT_W-1:0] s);
    wait_hi(dq_req_valid, "R2 dq_req_valid");
    check(dq_req_queue == q, "R2 dq queue", dq_req_queue, q);
    s = dq_req_slot; dq_req_ready = 1;
    @(negedge clk); dq_req_ready = 0;
  endtask

  task automatic give_resp(input logic [SLOT_W-1:0] s, input logic e,
                           input logic [ADDR_W-1:0] a, input logic [OP_W-1:0] op);
    dq_resp_valid = 1; dq_resp_slot = s; dq_resp_empty = e; dq_resp_addr = a; dq_resp_op = op;
    @(negedge clk); dq_resp_valid = 0;
  endtask

  task automatic take_status(input logic [TAG_W-1:0] t, input logic e);
    wait_hi(st_valid, "R3 st_valid");
    check(st_tag == t, "R10 status tag", st_tag, t);
    check(st_empty == e, "R3 status empty", st_empty, e);
    check(!rd_valid, "R3 no read before status", rd_valid, 0);
    st_ready = 1; @(negedge clk); st_ready = 0;
  endtask

  task automatic take_rd(input logic [ADDR_W-1:0] a, input logic [SLOT_W-1:0] s);
    wait_hi(rd_valid, "R4 rd_valid");
    check(rd_addr == a, "R4 rd addr", rd_addr, a);
    check(rd_slot == s, "R4 rd slot", rd_slot, s);
    rd_ready = 1; @(negedge clk); rd_ready = 0;
  endtask

  task automatic fill_done(input logic [SLOT_W-1:0] s, input logic [TAG_W-1:0] t);
    for (int w = 0; w < DESC_WORDS; w++) begin
      ram_we = 1; ram_waddr = RAM_AW'(int'(s) * DESC_WORDS + w); ram_wdata = exp_word(t, w);
      @(negedge clk);
    end
    ram_we = 0;
    rd_done_valid = 1; rd_done_slot = s;
    @(negedge clk); rd_done_valid = 0;
  endtask

  task automatic take_commit(input logic [OP_W-1:0] op);
    wait_hi(cm_valid, "R5 cm_valid");
    check(cm_op == op, "R5 commit op", cm_op, op);
    cm_ready = 1; @(negedge clk); cm_ready = 0;
  endtask

  task automatic take_stream(input int stall, output logic [TAG_W-1:0] tid);
    wait_hi(m_tvalid, "R6 m_tvalid");
    tid = m_tid;
    for (int k = 0; k < stall; k++) begin
      logic [DATA_W-1:0] d0 = m_tdata;
      @(negedge clk);
      check(m_tvalid && m_tdata == d0 && m_tid == tid, "R7 stream hold", m_tdata, d0);
    end
    for (int w = 0; w < DESC_WORDS; w++) begin
      check(m_tvalid, "R6 beat valid", m_tvalid, 1);
      check(m_tdata == exp_word(tid, w), "R6 beat data", m_tdata, exp_word(tid, w));
      check(m_tlast == (w == DESC_WORDS - 1), "R6 tlast", m_tlast, w == DESC_WORDS - 1);
      check(m_tid == tid, "R6 tid", m_tid, tid);
      m_tready = 1; @(negedge clk);
    end
    m_tready = 0;
  endtask

  task automatic t_reset;
    check(req_ready == 1, "R1 req_ready", req_ready, 1);
    check({dq_req_valid, st_valid, rd_valid, cm_valid, m_tvalid} == 5'b0,
          "R1 valids low", {dq_req_valid, st_valid, rd_valid, cm_valid, m_tvalid}, 0);
  endtask

  task automatic t_single(input logic [TAG_W-1:0] t, input int stall);
    logic [SLOT_W-1:0] s;
    logic [TAG_W-1:0] got;
    send_req(t, 8'h12 + 8'(t));
    take_dq(8'h12 + 8'(t), s);
    give_resp(s, 1'b0, 32'h1000_0000 + 32'(t), 4'(t + 1));
    take_status(t, 1'b0);
    take_rd(32'h1000_0000 + 32'(t), s);
    repeat (5) @(negedge clk);
    check(!cm_valid, "R5 no commit before done", cm_valid, 0);
    check(!m_tvalid, "R5 no stream before commit", m_tvalid, 0);
    fill_done(s, t);
    take_commit(4'(t + 1));
    take_stream(stall, got);
    check(got == t, "R6 stream tag", got, t);
    @(negedge clk);
    check(req_ready, "R8 slot freed after tlast", req_ready, 1);
  endtask

  task automatic t_empty;
    logic [SLOT_W-1:0] s;
    send_req(4'h7, 8'h55);
    take_dq(8'h55, s);
    give_resp(s, 1'b1, 32'hDEAD_0000, 4'h9);
    take_status(4'h7, 1'b1);
    for (int k = 0; k < 10; k++) begin
      check(!rd_valid && !cm_valid && !m_tvalid, "R9 nothing after empty",
            {rd_valid, cm_valid, m_tvalid}, 0);
      @(negedge clk);
    end
    check(req_ready, "R9 slot freed after empty", req_ready, 1);
  endtask

  task automatic t_many;
    logic [SLOT_W-1:0] s [SLOTS];
    logic [TAG_W-1:0] got;
    logic [SLOTS-1:0] seen = '0;
    for (int i = 0; i < SLOTS; i++) begin
      send_req(4'(i + 8), 8'(i + 32));
      take_dq(8'(i + 32), s[i]);
    end
    check(!req_ready, "R8 full", req_ready, 0);
    for (int i = SLOTS - 1; i >= 0; i--) begin
      give_resp(s[i], 1'b0, 32'h2000_0000 + 32'(i), 4'(i + 3));
      take_status(4'(i + 8), 1'b0);
      take_rd(32'h2000_0000 + 32'(i), s[i]);
    end
    for (int i = 0; i < SLOTS; i++) begin
      fill_done(s[i], 4'(i + 8));
      take_commit(4'(i + 3));
    end
    for (int i = 0; i < SLOTS; i++) begin
      take_stream(i, got);
      check(got >= 8 && got < 8 + SLOTS && !seen[got - 8], "R6 distinct stream tag", got, 8);
      if (got >= 8 && got < 8 + SLOTS) seen[got - 8] = 1'b1;
    end
    @(negedge clk);
    check(req_ready, "R8 free again", req_ready, 1);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single(4'h3, 0);
    t_empty();
    t_single(4'h5, 3);
    t_many();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule